// File: doc/BRIEF.md
# Zero-Overhead Repeat Loop Controller

This block gives a small processor front end with 16-bit instructions a hardware repeat loop. It decodes the loop-setup instructions and keeps three values: the loop start address, the loop end address and a 12-bit repeat count. The count sits at bits [27:16] of the status register. The start and end addresses can be loaded relative to the program counter, or written through the general control-register path. Both addresses can be read back into a general register. Every setup instruction takes effect in one clock.

On each fetch the controller compares the fetch address with the loop end address. If the count is above one on a match, it steers the next fetch address to the loop start and lowers the count by one. This happens in the same cycle, so the taken loop costs no cycles. On the last pass the count drops to zero and fetch carries on past the loop end. A count of zero turns looping off. The fetch unit uses `next_fetch` as its next address. The register file takes `rd_en`, `rd_idx` and `rd_data` for the read-back instructions.

Top module: `rptloop_top`

## Requirements
- R1: After reset the loop start, the loop end and the count are all 0. With no loop active, `next_fetch` equals `fetch_addr + 2` and `loop_taken` is 0.
- R2: A valid instruction with bits [15:8] = 8'h82 loads the count with its bits [7:0] and clears count bits [11:8]. The new count is visible on `rc_q` after the clock edge.
- R3: A valid instruction with bits [15:12] = 4'h4 and bits [7:0] = 8'h14 loads the count from `gpr_lo[11:0]`.
- R4: A valid instruction with bits [15:8] = 8'h8C loads the loop start with `insn_pc + 4 + 2*d`, where d is bits [7:0] zero-extended. With bits [15:8] = 8'h8E the same value goes to the loop end instead.
- R5: A valid instruction 0000nnnn01100010 raises `rd_en` in the same cycle, with `rd_idx` = n and `rd_data` = loop start. The instruction 0000nnnn01110010 does the same with the loop end. `rd_en` is 0 for every other word.
- R6: When `ctl_we` is 1, `ctl_sel` picks the target: 0 writes the loop start from `ctl_data`, 1 writes the loop end, and 2 loads the count from `ctl_data[27:16]`. The other bits of `ctl_data` have no effect on the count, and selector 3 changes nothing.
- R7: When `fetch_valid` is 1, `fetch_addr` equals the loop end and the count is greater than 1, `next_fetch` equals the loop start and `loop_taken` is 1 in the same cycle. The count is one lower after the edge.
- R8: When the fetch matches the loop end and the count is 1, `next_fetch` is `fetch_addr + 2` and `loop_taken` is 0. The count becomes 0.
- R9: While the count is 0, a fetch at the loop end is not redirected and leaves the count unchanged.
- R10: A count load by instruction or by control write in the same cycle as a loop-end match wins over the decrement.
- R11: Instructions other than the setup forms, and any word presented with `insn_valid` at 0, leave the loop start, the loop end and the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word is executing this cycle |
| insn | input | 16 | Instruction word |
| insn_pc | input | 32 | Address of the executing instruction |
| gpr_lo | input | 12 | Low bits of general register n |
| ctl_we | input | 1 | Control-register write strobe |
| ctl_sel | input | 2 | Control write target: 0 start, 1 end, 2 status, 3 none |
| ctl_data | input | 32 | Control-register write data |
| fetch_valid | input | 1 | A fetch is issued at fetch_addr this cycle |
| fetch_addr | input | 32 | Current fetch address |
| next_fetch | output | 32 | Address of the following fetch |
| loop_taken | output | 1 | Fetch redirected to loop start this cycle |
| rd_en | output | 1 | Read-back result for register n is valid |
| rd_idx | output | 4 | Destination register index n |
| rd_data | output | 32 | Read-back value |
| rs_q | output | 32 | Current loop start address |
| re_q | output | 32 | Current loop end address |
| rc_q | output | 12 | Current repeat count |

## Verification
The assertions assume that `fetch_valid` rises only for real fetches and that a control write and a setup instruction never target the count in the same cycle. They also assume that the fetch address never wraps past the top of the address space. The stimulus keeps to this. Setup instructions and control writes go in separate cycles, except in the one deliberate case where a count load meets a loop-end match. Fetch walks run at small addresses, so `fetch_addr + 2` never overflows.

// File: rtl/rptloop_pkg.sv
`timescale 1ns/1ps
package rptloop_pkg;

  typedef enum logic [2:0] {
    LOP_NONE,
    LOP_CNT_IMM,
    LOP_CNT_REG,
    LOP_LD_START,
    LOP_LD_END,
    LOP_RD_START,
    LOP_RD_END
  } loop_op_e;

  // PC-relative loop address: pc + 4 + 2*zero-extended displacement
  function automatic logic [31:0] pcrel_target(input logic [31:0] pc,
                                               input logic [7:0]  disp);
    return pc + 32'd4 + {23'd0, disp, 1'b0};
  endfunction

  // Count after a loop-end match
  function automatic logic [11:0] count_after_hit(input logic [11:0] cnt);
    return cnt - 12'd1;
  endfunction

endpackage

// File: rtl/rptloop_decode.sv
`timescale 1ns/1ps
module rptloop_decode
  import rptloop_pkg::*;
(
  input  logic        insn_valid,
  input  logic [15:0] insn,
  output loop_op_e    op,
  output logic [3:0]  rn_idx,
  output logic [7:0]  imm8
);

  always_comb begin
    op = LOP_NONE;
    if (insn_valid) begin
      if (insn[15:8] == 8'h82)
        op = LOP_CNT_IMM;
      else if (insn[15:8] == 8'h8C)
        op = LOP_LD_START;
      else if (insn[15:8] == 8'h8E)
        op = LOP_LD_END;
      else if (insn[15:12] == 4'h4 && insn[7:0] == 8'h14)
        op = LOP_CNT_REG;
      else if (insn[15:12] == 4'h0 && insn[7:0] == 8'h62)
        op = LOP_RD_START;
      else if (insn[15:12] == 4'h0 && insn[7:0] == 8'h72)
        op = LOP_RD_END;
    end
  end

  assign rn_idx = insn[11:8];
  assign imm8   = insn[7:0];

endmodule

// File: rtl/rptloop_regs.sv
`timescale 1ns/1ps
module rptloop_regs
  import rptloop_pkg::*;
#(
  parameter int AW   = 32,
  parameter int RC_W = 12,
  parameter int RC_LSB = 16
)(
  input  logic            clk,
  input  logic            rst_n,
  input  loop_op_e        op,
  input  logic [7:0]      imm8,
  input  logic [AW-1:0]   pc,
  input  logic [RC_W-1:0] gpr_lo,
  input  logic            ctl_we,
  input  logic [1:0]      ctl_sel,
  input  logic [31:0]     ctl_data,
  input  logic            rc_dec,
  output logic [AW-1:0]   rs,
  output logic [AW-1:0]   re,
  output logic [RC_W-1:0] rc,
  output logic            rc_wr
);

  logic [31:0]     pc32;
  logic [31:0]     tgt32;
  logic [AW-1:0]   tgt;
  logic [RC_W-1:0] rc_load;
  logic [RC_W-1:0] rc_next_dec;
  logic            ctl_rc_wr;

  always_comb begin
    pc32         = '0;
    pc32[AW-1:0] = pc;
    tgt32        = pcrel_target(pc32, imm8);
    tgt          = tgt32[AW-1:0];
  end

  assign ctl_rc_wr = ctl_we && (ctl_sel == 2'd2);
  assign rc_wr     = (op == LOP_CNT_IMM) || (op == LOP_CNT_REG) || ctl_rc_wr;
  assign rc_next_dec = rc - {{(RC_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (op == LOP_CNT_IMM)
      rc_load = {{(RC_W-8){1'b0}}, imm8};
    else if (op == LOP_CNT_REG)
      rc_load = gpr_lo;
    else
      rc_load = ctl_data[RC_LSB +: RC_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs <= '0;
      re <= '0;
      rc <= '0;
    end else begin
      if (op == LOP_LD_START)
        rs <= tgt;
      else if (ctl_we && ctl_sel == 2'd0)
        rs <= ctl_data[AW-1:0];

      if (op == LOP_LD_END)
        re <= tgt;
      else if (ctl_we && ctl_sel == 2'd1)
        re <= ctl_data[AW-1:0];

      if (rc_wr)
        rc <= rc_load;
      else if (rc_dec)
        rc <= rc_next_dec;
    end
  end

endmodule

// File: rtl/rptloop_fetch.sv
`timescale 1ns/1ps
module rptloop_fetch #(
  parameter int AW   = 32,
  parameter int RC_W = 12
)(
  input  logic            fetch_valid,
  input  logic [AW-1:0]   fetch_addr,
  input  logic [AW-1:0]   rs,
  input  logic [AW-1:0]   re,
  input  logic [RC_W-1:0] rc,
  output logic            loop_hit,
  output logic            redirect,
  output logic [AW-1:0]   next_fetch
);

  logic cnt_live;
  logic cnt_more;

  assign cnt_live   = (rc != '0);
  assign cnt_more   = (rc > {{(RC_W-1){1'b0}}, 1'b1});
  assign loop_hit   = fetch_valid && cnt_live && (fetch_addr == re);
  assign redirect   = loop_hit && cnt_more;
  assign next_fetch = redirect ? rs : fetch_addr + {{(AW-2){1'b0}}, 2'b10};

endmodule

// File: rtl/rptloop_top.sv
`timescale 1ns/1ps
module rptloop_top
  import rptloop_pkg::*;
#(
  parameter int AW   = 32,
  parameter int RC_W = 12
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  input  logic [15:0]     insn,
  input  logic [AW-1:0]   insn_pc,
  input  logic [RC_W-1:0] gpr_lo,
  input  logic            ctl_we,
  input  logic [1:0]      ctl_sel,
  input  logic [31:0]     ctl_data,
  input  logic            fetch_valid,
  input  logic [AW-1:0]   fetch_addr,
  output logic [AW-1:0]   next_fetch,
  output logic            loop_taken,
  output logic            rd_en,
  output logic [3:0]      rd_idx,
  output logic [31:0]     rd_data,
  output logic [AW-1:0]   rs_q,
  output logic [AW-1:0]   re_q,
  output logic [RC_W-1:0] rc_q
);

  loop_op_e   op;
  logic [3:0] rn_idx;
  logic [7:0] imm8;
  logic       loop_hit;
  logic       rc_wr;

  rptloop_decode u_dec (
    .insn_valid (insn_valid),
    .insn       (insn),
    .op         (op),
    .rn_idx     (rn_idx),
    .imm8       (imm8)
  );

  rptloop_regs #(.AW(AW), .RC_W(RC_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .imm8     (imm8),
    .pc       (insn_pc),
    .gpr_lo   (gpr_lo),
    .ctl_we   (ctl_we),
    .ctl_sel  (ctl_sel),
    .ctl_data (ctl_data),
    .rc_dec   (loop_hit),
    .rs       (rs_q),
    .re       (re_q),
    .rc       (rc_q),
    .rc_wr    (rc_wr)
  );

  rptloop_fetch #(.AW(AW), .RC_W(RC_W)) u_fetch (
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .rs          (rs_q),
    .re          (re_q),
    .rc          (rc_q),
    .loop_hit    (loop_hit),
    .redirect    (loop_taken),
    .next_fetch  (next_fetch)
  );

  always_comb begin
    rd_data = '0;
    if (op == LOP_RD_START)
      rd_data[AW-1:0] = rs_q;
    else if (op == LOP_RD_END)
      rd_data[AW-1:0] = re_q;
  end

  assign rd_en  = (op == LOP_RD_START) || (op == LOP_RD_END);
  assign rd_idx = rn_idx;

endmodule

// File: rtl/rptloop_chk.sv
`timescale 1ns/1ps
module rptloop_chk #(
  parameter int AW   = 32,
  parameter int RC_W = 12
)(
  input logic            clk,
  input logic            rst_n,
  input logic            insn_valid,
  input logic [15:0]     insn,
  input logic            fetch_valid,
  input logic [AW-1:0]   fetch_addr,
  input logic [AW-1:0]   next_fetch,
  input logic            loop_taken,
  input logic [AW-1:0]   rs_q,
  input logic [AW-1:0]   re_q,
  input logic [RC_W-1:0] rc_q,
  input logic            loop_hit,
  input logic            rc_wr
);

  p_redirect_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loop_taken |-> next_fetch == rs_q);

  p_redirect_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loop_taken |-> (fetch_valid && fetch_addr == re_q && rc_q > 1));

  p_count_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_hit && !rc_wr) |=> rc_q == $past(rc_q) - 1'b1);

  p_last_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_hit && rc_q == 1) |-> (!loop_taken && next_fetch == fetch_addr + 2));

  p_zero_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_q == 0) |-> (!loop_hit && !loop_taken));

  p_imm_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[15:8] == 8'h82) |=> rc_q == RC_W'($past(insn[7:0])));

  p_count_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rc_wr && !loop_hit) |=> $stable(rc_q));

endmodule

bind rptloop_top rptloop_chk #(.AW(AW), .RC_W(RC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .insn_valid  (insn_valid),
  .insn        (insn),
  .fetch_valid (fetch_valid),
  .fetch_addr  (fetch_addr),
  .next_fetch  (next_fetch),
  .loop_taken  (loop_taken),
  .rs_q        (rs_q),
  .re_q        (re_q),
  .rc_q        (rc_q),
  .loop_hit    (loop_hit),
  .rc_wr       (rc_wr)
);

// File: tb/sim_rptloop_top.sv
`timescale 1ns/1ps
module sim_rptloop_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [15:0] insn = '0;
  logic [31:0] insn_pc = '0;
  logic [11:0] gpr_lo = '0;
  logic        ctl_we = 1'b0;
  logic [1:0]  ctl_sel = 2'd3;
  logic [31:0] ctl_data = '0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic [31:0] next_fetch;
  logic        loop_taken;
  logic        rd_en;
  logic [3:0]  rd_idx;
  logic [31:0] rd_data;
  logic [31:0] rs_q;
  logic [31:0] re_q;
  logic [11:0] rc_q;

  int nvec = 0;
  int nerr = 0;
  logic [31:0] m_rs = '0, m_re = '0;
  logic [11:0] m_rc = '0;

  always #5 clk = ~clk;

  rptloop_top u0 (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .insn_pc(insn_pc), .gpr_lo(gpr_lo), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
    .ctl_data(ctl_data), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .next_fetch(next_fetch), .loop_taken(loop_taken), .rd_en(rd_en),
    .rd_idx(rd_idx), .rd_data(rd_data), .rs_q(rs_q), .re_q(re_q), .rc_q(rc_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(req, rs_q, m_rs);
    chk(req, re_q, m_re);
    chk(req, {20'd0, rc_q}, {20'd0, m_rc});
  endtask

  // one instruction cycle; state sampled at the following negedge
  task automatic exec(input logic [15:0] w, input logic [31:0] pc, input logic [11:0] g);
    @(negedge clk);
    insn = w; insn_pc = pc; gpr_lo = g; insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0; insn = '0;
  endtask

  task automatic ctl_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    ctl_we = 1'b1; ctl_sel = sel; ctl_data = d;
    @(negedge clk);
    ctl_we = 1'b0; ctl_sel = 2'd3;
  endtask

  task automatic readback(input string req);
    @(negedge clk);
    insn = {4'h0, 4'd5, 8'h62}; insn_valid = 1'b1;
    #1;
    chk({req, " R5 start rd"}, {rd_en, 27'd0, rd_idx}, {1'b1, 27'd0, 4'd5});
    chk({req, " R5 start data"}, rd_data, m_rs);
    @(negedge clk);
    insn = {4'h0, 4'd9, 8'h72};
    #1;
    chk({req, " R5 end rd"}, {rd_en, 27'd0, rd_idx}, {1'b1, 27'd0, 4'd9});
    chk({req, " R5 end data"}, rd_data, m_re);
    @(negedge clk);
    insn_valid = 1'b0; insn = '0;
    chk_state({req, " state"});
  endtask

  function automatic logic [31:0] pcrel(input logic [31:0] pc, input int d);
    return pc + 4 + 2 * d;
  endfunction

  // walk fetches from base; expected next address from the loop rules
  task automatic run_loop(input logic [31:0] base, input int len, input int n);
    logic [31:0] a;
    logic [31:0] en;
    logic        et;
    int          ends_seen;
    exec({8'h8C, 8'd0}, base - 4, 12'd0);
    m_rs = base;
    exec({8'h8E, 8'(len - 1)}, base - 4, 12'd0);
    m_re = base + 32'(2 * (len - 1));
    exec({8'h82, 8'(n)}, 32'd0, 12'd0);
    m_rc = 12'(n);
    chk_state("R4 R2 loop setup");
    a = base;
    ends_seen = 0;
    for (int step = 0; step < 200 && a <= m_re; step++) begin
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = a;
      #1;
      et = (m_rc != 0) && (a == m_re) && (m_rc > 1);
      en = et ? m_rs : a + 2;
      chk(m_rc > 1 ? "R7 next" : "R8 R9 next", next_fetch, en);
      chk(m_rc > 1 ? "R7 taken" : "R8 R9 taken", {31'd0, loop_taken}, {31'd0, et});
      if (a == m_re) ends_seen++;
      if (m_rc != 0 && a == m_re) m_rc = m_rc - 1;
      a = en;
    end
    @(negedge clk);
    fetch_valid = 1'b0;
    chk("R8 final count", {20'd0, rc_q}, 32'd0);
    chk("R7 R8 R9 passes", ends_seen, (n == 0) ? 1 : n);
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=done", nvec);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_state("R1 reset");
    fetch_valid = 1'b1; fetch_addr = 32'h0;
    #1;
    chk("R1 next", next_fetch, 32'h2);
    chk("R1 taken", {31'd0, loop_taken}, 32'd0);
    @(negedge clk);
    fetch_valid = 1'b0;
    chk("R1 R9 count hold", {20'd0, rc_q}, 32'd0);

    // R2 all immediate values
    for (int i = 0; i < 256; i++) begin
      exec({8'h82, 8'(i)}, 32'd0, 12'hFFF);
      m_rc = 12'(i);
      chk("R2 imm count", {20'd0, rc_q}, {20'd0, m_rc});
    end

    // R3 register form, various n and values
    for (int i = 0; i < 16; i++) begin
      logic [11:0] g;
      g = 12'((i * 12'h1A7) ^ (i << 8));
      exec({4'h4, 4'(i), 8'h14}, 32'd0, g);
      m_rc = g;
      chk("R3 reg count", {20'd0, rc_q}, {20'd0, m_rc});
    end

    // R4 PC-relative loads over all displacements, R5 readback
    for (int d = 0; d < 256; d++) begin
      logic [31:0] pc;
      pc = 32'h0000_1000 + 32'(d * 6);
      exec({8'h8C, 8'(d)}, pc, 12'd0);
      m_rs = pcrel(pc, d);
      chk("R4 start", rs_q, m_rs);
      exec({8'h8E, 8'(255 - d)}, pc + 2, 12'd0);
      m_re = pcrel(pc + 2, 255 - d);
      chk("R4 end", re_q, m_re);
    end
    exec({8'h8C, 8'hFF}, 32'hFFFF_FF00, 12'd0);
    m_rs = pcrel(32'hFFFF_FF00, 255);
    readback("R4 high pc");

    // nested setups with readback after each
    exec({8'h8C, 8'h10}, 32'h200, 12'd0);  m_rs = pcrel(32'h200, 16);
    readback("R4 nest start");
    exec({8'h8E, 8'h20}, 32'h202, 12'd0);  m_re = pcrel(32'h202, 32);
    readback("R4 nest end");
    exec({8'h82, 8'h03}, 32'h204, 12'd0);  m_rc = 12'd3;
    readback("R2 nest count");
    exec({4'h4, 4'd2, 8'h14}, 32'h206, 12'hABC); m_rc = 12'hABC;
    readback("R3 nest count");

    // R5 non-readback word keeps rd_en low
    @(negedge clk);
    insn = 16'h0009; insn_valid = 1'b1;
    #1;
    chk("R5 rd_en idle", {31'd0, rd_en}, 32'd0);
    @(negedge clk);
    insn_valid = 1'b0;
    chk_state("R11 other insn");

    // R11 setup word with valid low
    @(negedge clk);
    insn = 16'h8255; insn_pc = 32'h40; insn_valid = 1'b0;
    @(negedge clk);
    insn = 16'h8C44;
    @(negedge clk);
    insn = '0;
    chk_state("R11 invalid word");

    // R6 control path
    ctl_write(2'd0, 32'h0000_3000); m_rs = 32'h0000_3000;
    ctl_write(2'd1, 32'h0000_3010); m_re = 32'h0000_3010;
    ctl_write(2'd2, 32'hF5A5_5A5A); m_rc = 12'h5A5;
    chk_state("R6 ctl write");
    ctl_write(2'd2, 32'hF000_FFFF); m_rc = 12'h000;
    chk_state("R6 ctl sr outside field");
    ctl_write(2'd3, 32'h1234_5678);
    chk_state("R6 ctl none");

    // R7 R8 R9 loops: length 1 (start equals end) to 3, counts 0 to 6
    for (int len = 1; len <= 3; len++)
      for (int n = 0; n <= 6; n++)
        run_loop(32'h0000_0400 + 32'(len * 32'h100), len, n);

    // R10 count load during a loop-end hit
    exec({8'h82, 8'd3}, 32'd0, 12'd0); m_rc = 12'd3;
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = m_re;
    insn = {8'h82, 8'd7}; insn_valid = 1'b1;
    #1;
    chk("R10 redirect", next_fetch, m_rs);
    @(negedge clk);
    fetch_valid = 1'b0; insn_valid = 1'b0; insn = '0;
    m_rc = 12'd7;
    chk("R10 load wins", {20'd0, rc_q}, {20'd0, m_rc});
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = m_re;
    ctl_we = 1'b1; ctl_sel = 2'd2; ctl_data = 32'h0042_0000;
    @(negedge clk);
    fetch_valid = 1'b0; ctl_we = 1'b0; ctl_sel = 2'd3;
    chk("R10 ctl load wins", {20'd0, rc_q}, 32'h042);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule